// File: doc/BRIEF.md
# Frame-Synchronous Control and Event Registers

This block is the register file and event logic that sits beside the pixel path of a streaming video core. Software reaches it through a plain write strobe with address and data, and reads it back combinationally. Its control word sets the core enable, bypass and test-pattern selects. It also holds a commit semaphore and two reset requests. One is a software reset that holds everything at its initial value. The other is a frame-synchronised reset that waits for a frame boundary, fires once and clears itself.

The block watches accepted pixel transfers, each marked with start-of-frame and end-of-line. It follows the frame geometry with a small state machine. `ST_HOLD` is entered from any state while the software reset is set, and leaves to `ST_IDLE` once the reset is released. `ST_IDLE` moves to `ST_ACTIVE` when a start-of-frame pixel is accepted. `ST_ACTIVE` returns to `ST_IDLE` on the end-of-line of the last line. A start-of-frame that arrives inside a frame restarts the frame and stays in `ST_ACTIVE`. A frame-synchronised reset forces `ST_IDLE`.

The frame size that software writes goes into a shadow copy. That copy moves to the live geometry only at a frame end while the commit bit is 1. Sticky status and error flags record events and are cleared by writing ones. A mask over the status bits drives a level interrupt. Free-running counters of frames, lines and pixels can be read at any time.

Top module: `vid_frame_ctl`

## Requirements
- R1: After reset the control, status, error and interrupt-enable registers read 0, all three counters read 0, `irq` and `stream_rst` are 0, and both the shadow and the live frame size hold the parameter defaults.
- R2: Control register (offset 0x00): bit 0 enables the core (`core_en`), bit 1 is the commit bit, bit 4 drives `bypass_en`, bit 5 drives `tpg_en`, bit 30 requests a frame-synchronised reset and bit 31 is the software reset. All other bits read 0.
- R3: The live frame size (`live_width`, `live_height`) changes only at a frame end with the commit bit at 1. It then takes the shadow value. A write to the shadow has no effect on the live size until that moment.
- R4: A frame-synchronised reset request acts in the cycle after it is written if the tracker is idle, or else at the edge that accepts the frame's last pixel. At that edge it returns the tracker to idle and clears bit 30. In the following cycle `stream_rst` is high for exactly one cycle.
- R5: While control bit 31 is 1, `stream_rst` is high. Status, error, interrupt enable, counters and both frame-size copies are held at their reset values. Writes to them are ignored and pixels are not taken. The control register stays writable so that the reset can be released.
- R6: Status register (offset 0x04): bit 0 is set when a start-of-frame pixel is accepted, bit 1 at a frame end, and bit 16 on any error event. Each bit stays set until a 1 is written to it. An event in the same cycle as the clear leaves the bit set.
- R7: Error register (offset 0x08), write-one-to-clear: bit 0 is end-of-line before the last column, bit 1 is the last column passed without end-of-line, bit 2 is start-of-frame inside a frame (the frame restarts at that pixel), and bit 3 is a pixel without start-of-frame while idle (the pixel is dropped from the geometry).
- R8: `irq` is high whenever any status bit is set whose bit in the interrupt-enable register (offset 0x0C) is also set.
- R9: Counters at 0x14, 0x18 and 0x1C count completed frames, completed lines and accepted pixels.
- R10: With control bit 0 at 0, pixel transfers change no counter, flag or tracker state.
- R11: Offset 0x10 reads the version parameter and ignores writes. Unmapped or misaligned offsets read 0.
- R12: Frame size (offset 0x20): width in bits 12:0, height in bits 28:16, all other bits read 0. Values from 32 to 7680 are the intended range; any nonzero value is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pix_vld | input | 1 | A pixel transfer is accepted this cycle |
| pix_sof | input | 1 | The transfer is the first pixel of a frame |
| pix_eol | input | 1 | The transfer is the last pixel of a line |
| core_en | output | 1 | Core enable |
| bypass_en | output | 1 | Bypass select |
| tpg_en | output | 1 | Test-pattern select |
| stream_rst | output | 1 | Reset to the pixel path |
| live_width | output | 13 | Live pixels per line |
| live_height | output | 13 | Live lines per frame |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach from the ports are coincidences. One is a write-one-to-clear landing in the same cycle as the event that sets the same flag. The other is a frame-synchronised reset that is pending across the middle of a frame. The bench drives a register write and a start-of-frame pixel in one task call, so both are sampled at the same edge. It also writes the reset request after the first pixel of a frame, idles for several cycles, and then finishes the frame, so the pulse must appear exactly after the last pixel. A sweep over small committed geometries checks the counters and the live size arithmetically after every frame.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } trk_state_e;

    // control bit positions
    localparam int CTRL_EN     = 0;
    localparam int CTRL_COMMIT = 1;
    localparam int CTRL_BYPASS = 4;
    localparam int CTRL_TPG    = 5;
    localparam int CTRL_FSRST  = 30;
    localparam int CTRL_SWRST  = 31;
    localparam logic [31:0] CTRL_MASK = 32'hC000_0033;

    // byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_ERR  = 8'h08;
    localparam logic [7:0] OFF_IEN  = 8'h0C;
    localparam logic [7:0] OFF_VER  = 8'h10;
    localparam logic [7:0] OFF_FCNT = 8'h14;
    localparam logic [7:0] OFF_LCNT = 8'h18;
    localparam logic [7:0] OFF_PCNT = 8'h1C;
    localparam logic [7:0] OFF_SIZE = 8'h20;

    // status bank order (bank index -> register bit)
    localparam int STAT_N      = 3;
    localparam int SB_START    = 0;
    localparam int SB_EOF      = 1;
    localparam int SB_ERR      = 2;
    localparam int STAT_ERRBIT = 16;

    // error flag positions
    localparam int ERR_N         = 4;
    localparam int ERR_EOL_EARLY = 0;
    localparam int ERR_EOL_LATE  = 1;
    localparam int ERR_SOF_EARLY = 2;
    localparam int ERR_SOF_LATE  = 3;

endpackage

// File: rtl/vfc_flag_bank.sv
module vfc_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || hold) begin
                q[i] <= 1'b0;
            end else begin
                // a new event outranks a clear in the same cycle
                q[i] <= (q[i] & ~clr[i]) | set[i];
            end
        end

        a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !hold) |=> q[i]);
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr[i] && !hold) |=> q[i]);
    end

endmodule

// File: rtl/vfc_tracker.sv
module vfc_tracker
    import vfc_pkg::*;
#(
    parameter int DIM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             en,
    input  logic             fs_req,
    input  logic             pix_vld,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    output logic             ev_pixel,
    output logic             ev_start,
    output logic             ev_line_end,
    output logic             ev_frame_end,
    output logic [ERR_N-1:0] ev_err,
    output logic             fs_fire
);

    localparam logic [DIM_W-1:0] ONE     = {{(DIM_W-1){1'b0}}, 1'b1};
    localparam logic [DIM_W-1:0] DIM_MAX = '1;

    trk_state_e       state_q, state_d;
    logic [DIM_W-1:0] col_q, col_d, row_q, row_d;
    logic [DIM_W-1:0] c_eff, r_eff;
    logic             idle_fire, acc, restart, in_frame, line_px;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    // event decode and outputs
    always_comb begin
        idle_fire    = fs_req && !hold && (state_q == ST_IDLE);
        acc          = pix_vld && en && !hold && (state_q != ST_HOLD) && !idle_fire;
        restart      = acc && pix_sof;
        c_eff        = restart ? '0 : col_q;
        r_eff        = restart ? '0 : row_q;
        in_frame     = (state_q == ST_ACTIVE) || restart;
        line_px      = acc && in_frame;

        ev_pixel     = acc;
        ev_start     = restart;
        ev_line_end  = line_px && pix_eol;
        ev_frame_end = ev_line_end && (r_eff == height - ONE);

        ev_err                = '0;
        ev_err[ERR_EOL_EARLY] = line_px && pix_eol && (c_eff < width - ONE);
        ev_err[ERR_EOL_LATE]  = line_px && !pix_eol && (c_eff == width - ONE);
        ev_err[ERR_SOF_EARLY] = acc && pix_sof && (state_q == ST_ACTIVE);
        ev_err[ERR_SOF_LATE]  = acc && !pix_sof && (state_q == ST_IDLE);

        fs_fire      = idle_fire || (fs_req && ev_frame_end);
    end

    // next state and geometry
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        row_d   = row_q;
        unique case (state_q)
            ST_HOLD:   state_d = ST_IDLE;
            ST_IDLE:   if (restart && !ev_frame_end) state_d = ST_ACTIVE;
            ST_ACTIVE: if (ev_frame_end) state_d = ST_IDLE;
            default:   state_d = ST_HOLD;
        endcase
        if (line_px) begin
            if (pix_eol) begin
                col_d = '0;
                row_d = ev_frame_end ? '0 : r_eff + ONE;
            end else begin
                col_d = (c_eff == DIM_MAX) ? c_eff : c_eff + ONE;
                row_d = r_eff;
            end
        end
        if (fs_fire) begin
            state_d = ST_IDLE;
            col_d   = '0;
            row_d   = '0;
        end
        if (hold) begin
            state_d = ST_HOLD;
            col_d   = '0;
            row_d   = '0;
        end
    end

    a_r5_hold_enters: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == ST_HOLD));
    a_r4_fire_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_fire && !hold) |=> (state_q == ST_IDLE && col_q == '0 && row_q == '0));
    a_r7_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (col_q == '0 && row_q == '0));
    a_r10_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !hold && !fs_req && state_q != ST_HOLD)
            |=> ($stable(state_q) && $stable(col_q) && $stable(row_q)));

endmodule

// File: rtl/vfc_regs.sv
module vfc_regs
    import vfc_pkg::*;
#(
    parameter int          DIM_W   = 13,
    parameter int          CNT_W   = 32,
    parameter int          DEF_W   = 1920,
    parameter int          DEF_H   = 1080,
    parameter logic [31:0] VERSION = 32'h0301_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             ev_pixel,
    input  logic             ev_start,
    input  logic             ev_line_end,
    input  logic             ev_frame_end,
    input  logic [ERR_N-1:0] ev_err,
    input  logic             fs_fire,
    output logic [31:0]      ctrl_q,
    output logic [DIM_W-1:0] live_w,
    output logic [DIM_W-1:0] live_h,
    output logic             stream_rst,
    output logic             irq
);

    localparam logic [DIM_W-1:0] W_INIT    = DIM_W'(DEF_W);
    localparam logic [DIM_W-1:0] H_INIT    = DIM_W'(DEF_H);
    localparam logic [31:0]      STAT_MASK = 32'h0001_0003;

    logic             hold;
    logic             sel_ctrl, sel_stat, sel_err, sel_ien, sel_size;
    logic [31:0]      ien_q;
    logic [DIM_W-1:0] shd_w, shd_h;
    logic [CNT_W-1:0] fcnt, lcnt, pcnt;
    logic             fsr_q;
    logic [STAT_N-1:0] st_set, st_clr, st_q;
    logic [ERR_N-1:0]  er_clr, er_q;
    logic [31:0]      status32, size32;

    assign hold     = ctrl_q[CTRL_SWRST];
    assign sel_ctrl = wr && (addr == OFF_CTRL);
    assign sel_stat = wr && (addr == OFF_STAT);
    assign sel_err  = wr && (addr == OFF_ERR);
    assign sel_ien  = wr && (addr == OFF_IEN);
    assign sel_size = wr && (addr == OFF_SIZE);

    // control word: always writable, frame-sync request clears itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (sel_ctrl) begin
            ctrl_q <= wdata & CTRL_MASK;
        end else if (fs_fire) begin
            ctrl_q[CTRL_FSRST] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsr_q <= 1'b0;
        else        fsr_q <= fs_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hold)  ien_q <= '0;
        else if (sel_ien)    ien_q <= wdata & STAT_MASK;
    end

    // shadow and live frame size
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            shd_w  <= W_INIT;
            shd_h  <= H_INIT;
            live_w <= W_INIT;
            live_h <= H_INIT;
        end else begin
            if (sel_size) begin
                shd_w <= wdata[DIM_W-1:0];
                shd_h <= wdata[16 +: DIM_W];
            end
            if (ev_frame_end && ctrl_q[CTRL_COMMIT]) begin
                live_w <= shd_w;
                live_h <= shd_h;
            end
        end
    end

    // throughput counters
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            fcnt <= '0;
            lcnt <= '0;
            pcnt <= '0;
        end else begin
            if (ev_frame_end) fcnt <= fcnt + 1'b1;
            if (ev_line_end)  lcnt <= lcnt + 1'b1;
            if (ev_pixel)     pcnt <= pcnt + 1'b1;
        end
    end

    // sticky flags
    always_comb begin
        st_set           = '0;
        st_set[SB_START] = ev_start;
        st_set[SB_EOF]   = ev_frame_end;
        st_set[SB_ERR]   = |ev_err;
        st_clr           = '0;
        if (sel_stat) begin
            st_clr[SB_START] = wdata[0];
            st_clr[SB_EOF]   = wdata[1];
            st_clr[SB_ERR]   = wdata[STAT_ERRBIT];
        end
        er_clr = sel_err ? wdata[ERR_N-1:0] : '0;
    end

    vfc_flag_bank #(.N(STAT_N)) u_status (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .set(st_set), .clr(st_clr), .q(st_q)
    );

    vfc_flag_bank #(.N(ERR_N)) u_error (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .set(ev_err), .clr(er_clr), .q(er_q)
    );

    // read side
    always_comb begin
        status32              = '0;
        status32[0]           = st_q[SB_START];
        status32[1]           = st_q[SB_EOF];
        status32[STAT_ERRBIT] = st_q[SB_ERR];
        size32                = '0;
        size32[DIM_W-1:0]     = shd_w;
        size32[16 +: DIM_W]   = shd_h;
        case (addr)
            OFF_CTRL: rdata = ctrl_q;
            OFF_STAT: rdata = status32;
            OFF_ERR:  rdata = 32'(er_q);
            OFF_IEN:  rdata = ien_q;
            OFF_VER:  rdata = VERSION;
            OFF_FCNT: rdata = 32'(fcnt);
            OFF_LCNT: rdata = 32'(lcnt);
            OFF_PCNT: rdata = 32'(pcnt);
            OFF_SIZE: rdata = size32;
            default:  rdata = '0;
        endcase
    end

    assign irq        = |(status32 & ien_q);
    assign stream_rst = hold || fsr_q;

    a_r3_live_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({live_w, live_h})
            |-> ($past(ev_frame_end && ctrl_q[CTRL_COMMIT]) || $past(hold)));
    a_r4_fs_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_fire && !sel_ctrl) |=> !ctrl_q[CTRL_FSRST]);
    a_r4_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fs_fire |=> stream_rst);
    a_r5_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (fcnt == '0 && lcnt == '0 && pcnt == '0 && ien_q == '0));
    a_r9_pcnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ev_pixel) |=> $stable(pcnt));

endmodule

// File: rtl/vid_frame_ctl.sv
module vid_frame_ctl
    import vfc_pkg::*;
#(
    parameter int          DIM_W   = 13,
    parameter int          CNT_W   = 32,
    parameter int          DEF_W   = 1920,
    parameter int          DEF_H   = 1080,
    parameter logic [31:0] VERSION = 32'h0301_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             pix_vld,
    input  logic             pix_sof,
    input  logic             pix_eol,
    output logic             core_en,
    output logic             bypass_en,
    output logic             tpg_en,
    output logic             stream_rst,
    output logic [DIM_W-1:0] live_width,
    output logic [DIM_W-1:0] live_height,
    output logic             irq
);

    logic [31:0]      ctrl;
    logic             ev_pixel, ev_start, ev_line_end, ev_frame_end, fs_fire;
    logic [ERR_N-1:0] ev_err;

    vfc_tracker #(.DIM_W(DIM_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold         (ctrl[CTRL_SWRST]),
        .en           (ctrl[CTRL_EN]),
        .fs_req       (ctrl[CTRL_FSRST]),
        .pix_vld      (pix_vld),
        .pix_sof      (pix_sof),
        .pix_eol      (pix_eol),
        .width        (live_width),
        .height       (live_height),
        .ev_pixel     (ev_pixel),
        .ev_start     (ev_start),
        .ev_line_end  (ev_line_end),
        .ev_frame_end (ev_frame_end),
        .ev_err       (ev_err),
        .fs_fire      (fs_fire)
    );

    vfc_regs #(
        .DIM_W(DIM_W), .CNT_W(CNT_W), .DEF_W(DEF_W), .DEF_H(DEF_H), .VERSION(VERSION)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .ev_pixel     (ev_pixel),
        .ev_start     (ev_start),
        .ev_line_end  (ev_line_end),
        .ev_frame_end (ev_frame_end),
        .ev_err       (ev_err),
        .fs_fire      (fs_fire),
        .ctrl_q       (ctrl),
        .live_w       (live_width),
        .live_h       (live_height),
        .stream_rst   (stream_rst),
        .irq          (irq)
    );

    assign core_en   = ctrl[CTRL_EN];
    assign bypass_en = ctrl[CTRL_BYPASS];
    assign tpg_en    = ctrl[CTRL_TPG];

endmodule

// File: tb/tb_vid_frame_ctl.sv
module tb_vid_frame_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        pix_vld, pix_sof, pix_eol;
    logic        core_en, bypass_en, tpg_en, stream_rst, irq;
    logic [12:0] live_width, live_height;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_f  = 0;
    int exp_l  = 0;
    int exp_p  = 0;
    int cur_w, cur_h;

    always #2.5 clk = ~clk;

    vid_frame_ctl #(.DEF_W(6), .DEF_H(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_vld(pix_vld),
        .pix_sof(pix_sof), .pix_eol(pix_eol), .core_en(core_en),
        .bypass_en(bypass_en), .tpg_en(tpg_en), .stream_rst(stream_rst),
        .live_width(live_width), .live_height(live_height), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pix(input logic s, input logic e);
        pix_vld = 1'b1; pix_sof = s; pix_eol = e;
        tick();
        pix_vld = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
    endtask

    task automatic pix_wr(input logic s, input logic e, input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        pix_vld = 1'b1; pix_sof = s; pix_eol = e;
        tick();
        reg_wr = 1'b0; pix_vld = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
    endtask

    task automatic frame(input int w, input int h);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                pix(r == 0 && c == 0, c == w - 1);
        exp_f += 1; exp_l += h; exp_p += w * h;
    endtask

    function automatic logic [31:0] sz(input int w, input int h);
        return (32'(h) << 16) | 32'(w);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        pix_vld = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk_reg("R1 ctrl", 8'h00, 32'h0);
        chk_reg("R1 status", 8'h04, 32'h0);
        chk_reg("R1 error", 8'h08, 32'h0);
        chk_reg("R1 ien", 8'h0C, 32'h0);
        chk_reg("R1 size", 8'h20, sz(6, 4));
        chk_reg("R1 fcnt", 8'h14, 32'h0);
        chk_reg("R1 pcnt", 8'h1C, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 stream_rst", {31'b0, stream_rst}, 32'h0);
        chk("R1 live", {3'b0, live_height, 3'b0, live_width}, sz(6, 4));

        // R11 version and unmapped
        chk_reg("R11 version", 8'h10, 32'h0301_0000);
        wr_reg(8'h10, 32'h0);
        chk_reg("R11 version ro", 8'h10, 32'h0301_0000);
        chk_reg("R11 unmapped", 8'h24, 32'h0);
        chk_reg("R11 misaligned", 8'h01, 32'h0);

        // R10 disabled core ignores pixels
        pix(1, 0); pix(0, 0); pix(0, 1);
        chk_reg("R10 pcnt", 8'h1C, 32'h0);
        chk_reg("R10 status", 8'h04, 32'h0);

        // R2 control layout
        wr_reg(8'h00, 32'h3FFF_FFFF);
        chk_reg("R2 ctrl mask", 8'h00, 32'h0000_0033);
        chk("R2 outs", {29'b0, core_en, bypass_en, tpg_en}, 32'h7);
        wr_reg(8'h00, 32'h1);
        chk("R2 outs off", {29'b0, core_en, bypass_en, tpg_en}, 32'h4);

        // R6 R9 first frame at default geometry
        frame(6, 4);
        chk_reg("R6 status", 8'h04, 32'h3);
        chk_reg("R9 fcnt", 8'h14, 32'(exp_f));
        chk_reg("R9 lcnt", 8'h18, 32'(exp_l));
        chk_reg("R9 pcnt", 8'h1C, 32'(exp_p));
        chk_reg("R7 no err", 8'h08, 32'h0);

        // R8 interrupt mask
        chk("R8 masked", {31'b0, irq}, 32'h0);
        wr_reg(8'h0C, 32'h2);
        chk("R8 eof irq", {31'b0, irq}, 32'h1);
        wr_reg(8'h04, 32'h2);
        chk_reg("R6 w1c eof", 8'h04, 32'h1);
        chk("R8 cleared", {31'b0, irq}, 32'h0);
        wr_reg(8'h0C, 32'h1);
        chk("R8 start irq", {31'b0, irq}, 32'h1);
        wr_reg(8'h04, 32'h1);
        chk("R8 off", {31'b0, irq}, 32'h0);

        // R12 size fields, R3 shadow does not touch live
        wr_reg(8'h20, 32'hFFFF_FFFF);
        chk_reg("R12 size fields", 8'h20, 32'h1FFF_1FFF);
        chk("R3 live kept", 32'(live_width), 32'd6);
        wr_reg(8'h20, sz(4, 3));
        frame(6, 4);
        chk("R3 no commit", {3'b0, live_height, 3'b0, live_width}, sz(6, 4));
        wr_reg(8'h00, 32'h3);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 6; c++)
                if (!(r == 3 && c == 5)) pix(r == 0 && c == 0, c == 5);
        chk("R3 mid frame", {3'b0, live_height, 3'b0, live_width}, sz(6, 4));
        pix(0, 1);
        exp_f += 1; exp_l += 4; exp_p += 24;
        chk("R3 committed", {3'b0, live_height, 3'b0, live_width}, sz(4, 3));
        cur_w = 4; cur_h = 3;

        // R9 R3 sweep over small committed geometries
        for (int w = 2; w <= 5; w++) begin
            for (int h = 1; h <= 3; h++) begin
                wr_reg(8'h20, sz(w, h));
                frame(cur_w, cur_h);
                chk("R3 sweep live", {3'b0, live_height, 3'b0, live_width}, sz(w, h));
                chk_reg("R9 sweep fcnt", 8'h14, 32'(exp_f));
                chk_reg("R9 sweep lcnt", 8'h18, 32'(exp_l));
                chk_reg("R9 sweep pcnt", 8'h1C, 32'(exp_p));
                chk_reg("R7 sweep err", 8'h08, 32'h0);
                cur_w = w; cur_h = h;
            end
        end
        wr_reg(8'h20, sz(4, 3));
        frame(cur_w, cur_h);
        wr_reg(8'h04, 32'h0001_0003);

        // R7 sequence A: early and late end-of-line on a 4x3 frame
        pix(1, 0); pix(0, 1);
        pix(0, 0); pix(0, 0); pix(0, 0); pix(0, 1);
        pix(0, 0); pix(0, 0); pix(0, 0); pix(0, 0); pix(0, 1);
        chk_reg("R7 eol errs", 8'h08, 32'h3);
        chk_reg("R6 err status", 8'h04, 32'h0001_0003);
        wr_reg(8'h08, 32'h3);
        chk_reg("R7 w1c", 8'h08, 32'h0);
        chk_reg("R6 err bit kept", 8'h04, 32'h0001_0003);
        wr_reg(8'h04, 32'h0001_0003);

        // R7 sequence B: late and early start-of-frame
        pix(0, 0);
        chk_reg("R7 sof late", 8'h08, 32'h8);
        pix(1, 0); pix(1, 0);
        chk_reg("R7 sof early", 8'h08, 32'hC);
        pix(0, 0); pix(0, 0); pix(0, 1);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 4; c++) pix(0, c == 3);
        chk_reg("R7 restart frame", 8'h04, 32'h0001_0003);
        wr_reg(8'h08, 32'hF);
        wr_reg(8'h04, 32'h0001_0003);

        // R6 clear coinciding with a start event
        pix_wr(1, 0, 8'h04, 32'h1);
        chk_reg("R6 event beats clear", 8'h04, 32'h1);
        wr_reg(8'h04, 32'h1);
        chk_reg("R6 plain clear", 8'h04, 32'h0);
        pix(0, 0); pix(0, 0); pix(0, 1);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 4; c++) pix(0, c == 3);
        chk_reg("R6 eof only", 8'h04, 32'h2);

        // R4 frame-sync reset while idle
        wr_reg(8'h00, 32'h4000_0003);
        chk_reg("R4 request held", 8'h00, 32'h4000_0003);
        chk("R4 no pulse yet", {31'b0, stream_rst}, 32'h0);
        tick();
        chk("R4 idle pulse", {31'b0, stream_rst}, 32'h1);
        chk_reg("R4 idle selfclear", 8'h00, 32'h3);
        tick();
        chk("R4 pulse ends", {31'b0, stream_rst}, 32'h0);

        // R4 frame-sync reset pending across a frame
        pix(1, 0);
        wr_reg(8'h00, 32'h4000_0003);
        repeat (3) tick();
        chk("R4 waits", {31'b0, stream_rst}, 32'h0);
        chk_reg("R4 still pending", 8'h00, 32'h4000_0003);
        pix(0, 0); pix(0, 0); pix(0, 1);
        pix(0, 0); pix(0, 0); pix(0, 0); pix(0, 1);
        pix(0, 0); pix(0, 0); pix(0, 0);
        chk("R4 not before end", {31'b0, stream_rst}, 32'h0);
        pix(0, 1);
        chk("R4 frame-end pulse", {31'b0, stream_rst}, 32'h1);
        chk_reg("R4 end selfclear", 8'h00, 32'h3);
        tick();
        chk("R4 single pulse", {31'b0, stream_rst}, 32'h0);

        // R5 software reset
        wr_reg(8'h00, 32'h8000_0001);
        chk("R5 stream_rst", {31'b0, stream_rst}, 32'h1);
        chk_reg("R5 ctrl readable", 8'h00, 32'h8000_0001);
        tick();
        chk_reg("R5 fcnt", 8'h14, 32'h0);
        chk_reg("R5 pcnt", 8'h1C, 32'h0);
        chk_reg("R5 size default", 8'h20, sz(6, 4));
        chk("R5 live default", {3'b0, live_height, 3'b0, live_width}, sz(6, 4));
        chk_reg("R5 status", 8'h04, 32'h0);
        wr_reg(8'h0C, 32'h1);
        chk_reg("R5 ien ignored", 8'h0C, 32'h0);
        pix(1, 0);
        chk_reg("R5 pixel ignored", 8'h1C, 32'h0);
        wr_reg(8'h00, 32'h1);
        chk("R5 released", {31'b0, stream_rst}, 32'h0);
        tick();
        exp_f = 0; exp_l = 0; exp_p = 0;
        frame(6, 4);
        chk_reg("R5 R9 fcnt after", 8'h14, 32'(exp_f));
        chk_reg("R5 R9 pcnt after", 8'h1C, 32'(exp_p));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule